// File: doc/BRIEF.md
# UART Modem Status Register Unit

This unit watches the four active-low modem handshake lines of a serial port: clear-to-send, data-set-ready, ring and carrier detect. It resynchronises each line into the local clock domain. It then presents the lines, along with four sticky activity flags, as one status byte inside a 32-bit word on a simple read bus.

Each status bit reads as the inverse of its pin, so a line pulled low reads as 1. The activity flags record what the lines have done since the register was last read. A read of the register clears them. While any flag is set, a gated interrupt request is raised.

For self-test, a loopback input replaces the pins with four bits driven from the modem control register. In loopback, change detection runs on those bits and the pins have no effect.

Top module: `modem_stat_top`

## Requirements
- R1: `rdData` is 32 bits wide. Bits 31:8 are always 0, and the whole word is 0 whenever no read of the register is in progress. After reset, with all pins high, a read returns 0.
- R2: The status byte has this layout, from bit 7 down to bit 0: carrier, ring, data-set-ready, clear-to-send, carrier delta, ring trailing edge, data-set-ready delta, clear-to-send delta.
- R3: With loopback off, bits 7:4 are the inverse of the carrier, ring, data-set-ready and clear-to-send pins. A pin level applied before clock edge k is visible in a read after edge k+1.
- R4: With loopback on, the line bits take their values from the control bits, and any read shows them at once. The mapping is: request-to-send drives clear-to-send (bit 4), terminal-ready drives data-set-ready (bit 5), aux1 drives ring (bit 6) and aux2 drives carrier (bit 7). The pins are ignored.
- R5: The carrier, data-set-ready and clear-to-send delta flags set on a change of the selected line in either direction. Each flag is set at the clock edge after the one on which its line bit changed.
- R6: The ring flag (bit 2) sets only when the ring pin goes from 0 to 1, that is when bit 6 falls. A 1-to-0 pin transition does not set it.
- R7: A read clears all four flags at the edge that ends the read cycle. Without a read, flags never clear. A change detected on the same edge as a read leaves its flag set.
- R8: `irqOut` is 1 exactly when `irqEn` is 1 and at least one flag is set.
- R9: A write cycle (`busWrite`=1) to the register address returns 0 on `rdData` and does not clear the flags.
- R10: A read at any other address returns 0 and does not clear the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| clrToSendN | input | 1 | Clear-to-send pin, active low |
| dataSetRdyN | input | 1 | Data-set-ready pin, active low |
| ringN | input | 1 | Ring pin, active low |
| carrierN | input | 1 | Carrier-detect pin, active low |
| loopEn | input | 1 | Loopback select from the control register |
| reqSendCtl | input | 1 | Control request-to-send bit |
| termRdyCtl | input | 1 | Control terminal-ready bit |
| aux1Ctl | input | 1 | Control auxiliary output 1 |
| aux2Ctl | input | 1 | Control auxiliary output 2 |
| irqEn | input | 1 | Modem-status interrupt enable |
| busSel | input | 1 | Bus cycle valid |
| busWrite | input | 1 | Bus cycle is a write |
| busAddr | input | ADDR_W | Register offset of the cycle |
| rdData | output | 32 | Read data word |
| irqOut | output | 1 | Modem-status interrupt request |

## Verification
A corrupted synchroniser stage or previous-value register does not stay hidden. It shows up as a line bit that is late or early by a cycle, or as a spurious or missing delta flag, at the very next read. A flag register that drops or sticks is exposed on `irqOut` in the same cycle, because the request follows the flags directly. The bench mirrors the pin history, the previous line value and the flags in a behavioural model. It compares both outputs on every clock, so any divergence is reported at the cycle where it first appears.

// File: rtl/modem_stat_pkg.sv
package modem_stat_pkg;
  localparam int LINES  = 4;
  localparam int WORD_W = 32;

  localparam int IDX_CTS = 0;
  localparam int IDX_DSR = 1;
  localparam int IDX_RI  = 2;
  localparam int IDX_DCD = 3;

  typedef struct packed {
    logic rdEn;
    logic clrEn;
    logic useLoop;
  } statStrb_t;
endpackage

// File: rtl/modem_stat_ctrl.sv
module modem_stat_ctrl
  import modem_stat_pkg::*;
#(
  parameter int                ADDR_W     = 6,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              loopEn,
  input  logic              irqEn,
  input  logic              flagsAny,
  output statStrb_t         strb,
  output logic              irqOut
);
  logic addrHit;

  assign addrHit      = busSel && (busAddr == REG_OFFSET);
  assign strb.rdEn    = addrHit && !busWrite;
  assign strb.clrEn   = addrHit && !busWrite;
  assign strb.useLoop = loopEn;
  assign irqOut       = irqEn && flagsAny;

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !irqOut);

  // R9
  wr_noclr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWrite |-> !strb.clrEn);
endmodule

// File: rtl/modem_stat_dp.sv
module modem_stat_dp
  import modem_stat_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  pinsN,
  input  logic [LINES-1:0]  ctlBits,
  input  statStrb_t         strb,
  output logic [WORD_W-1:0] rdWord,
  output logic              flagsAny
);
  localparam int BYTE_W = 2 * LINES;

  logic [SYNC_STAGES-1:0] syncChain [LINES];
  logic [LINES-1:0]       syncOut;
  logic [LINES-1:0]       curSel;
  logic [LINES-1:0]       prevSel;
  logic [LINES-1:0]       chg;
  logic [LINES-1:0]       evt;
  logic [LINES-1:0]       flagQ;
  logic [BYTE_W-1:0]      statusByte;

  for (genvar i = 0; i < LINES; i++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncChain[i] <= '1;
      else       syncChain[i] <= {syncChain[i][SYNC_STAGES-2:0], pinsN[i]};
    end
    assign syncOut[i] = syncChain[i][SYNC_STAGES-1];
  end

  assign curSel = strb.useLoop ? ctlBits : ~syncOut;
  assign chg    = curSel ^ prevSel;

  for (genvar i = 0; i < LINES; i++) begin : g_evt
    if (i == IDX_RI) begin : g_trail
      assign evt[i] = prevSel[i] && !curSel[i];
    end else begin : g_any
      assign evt[i] = chg[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSel <= '0;
      flagQ   <= '0;
    end else begin
      prevSel <= curSel;
      flagQ   <= (strb.clrEn ? '0 : flagQ) | evt;
    end
  end

  assign statusByte = {curSel, flagQ};
  assign rdWord     = strb.rdEn ? {{(WORD_W-BYTE_W){1'b0}}, statusByte} : '0;
  assign flagsAny   = |flagQ;

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clrEn |=> ((flagQ & $past(flagQ)) == $past(flagQ)));

  // R7
  clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrEn && (curSel == prevSel)) |=> (flagQ == '0));

  // R6
  teri_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagQ[IDX_RI]) |-> ($past(prevSel[IDX_RI]) && !$past(curSel[IDX_RI])));
endmodule

// File: rtl/modem_stat_top.sv
module modem_stat_top
  import modem_stat_pkg::*;
#(
  parameter int                ADDR_W      = 6,
  parameter logic [ADDR_W-1:0] REG_OFFSET  = 'h18,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clrToSendN,
  input  logic              dataSetRdyN,
  input  logic              ringN,
  input  logic              carrierN,
  input  logic              loopEn,
  input  logic              reqSendCtl,
  input  logic              termRdyCtl,
  input  logic              aux1Ctl,
  input  logic              aux2Ctl,
  input  logic              irqEn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output logic [31:0]       rdData,
  output logic              irqOut
);
  statStrb_t         strb;
  logic              flagsAny;
  logic [LINES-1:0]  pinsN;
  logic [LINES-1:0]  ctlBits;
  logic [WORD_W-1:0] rdWord;

  assign pinsN   = {carrierN, ringN, dataSetRdyN, clrToSendN};
  assign ctlBits = {aux2Ctl, aux1Ctl, termRdyCtl, reqSendCtl};
  assign rdData  = rdWord;

  modem_stat_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .loopEn(loopEn), .irqEn(irqEn),
    .flagsAny(flagsAny), .strb(strb), .irqOut(irqOut)
  );

  modem_stat_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinsN(pinsN), .ctlBits(ctlBits),
    .strb(strb), .rdWord(rdWord), .flagsAny(flagsAny)
  );
endmodule

// File: tb/sim_modem_stat_top.sv
module sim_modem_stat_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] REG = 6'h18;

  logic clk = 0, rstN = 0;
  logic clrToSendN = 1, dataSetRdyN = 1, ringN = 1, carrierN = 1;
  logic loopEn = 0, reqSendCtl = 0, termRdyCtl = 0, aux1Ctl = 0, aux2Ctl = 0;
  logic irqEn = 0, busSel = 0, busWrite = 0;
  logic [ADDR_W-1:0] busAddr = REG;
  logic [31:0] rdData;
  logic irqOut;

  modem_stat_top u0 (
    .clk(clk), .rstN(rstN), .clrToSendN(clrToSendN), .dataSetRdyN(dataSetRdyN),
    .ringN(ringN), .carrierN(carrierN), .loopEn(loopEn), .reqSendCtl(reqSendCtl),
    .termRdyCtl(termRdyCtl), .aux1Ctl(aux1Ctl), .aux2Ctl(aux2Ctl), .irqEn(irqEn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .rdData(rdData), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [3:0] hist[$];
  logic [3:0] mPrev, mFlags;
  string tag = "R1";

  function automatic logic [3:0] pinVec();
    return {carrierN, ringN, dataSetRdyN, clrToSendN};
  endfunction

  function automatic logic [3:0] selNow();
    return loopEn ? {aux2Ctl, aux1Ctl, termRdyCtl, reqSendCtl} : ~hist[1];
  endfunction

  function automatic bit rdNow();
    return busSel && !busWrite && (busAddr == REG);
  endfunction

  task automatic check(string t, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    logic [3:0] cur, evt;
    cur = selNow();
    evt = cur ^ mPrev;
    evt[2] = mPrev[2] && !cur[2];
    mFlags = (rdNow() ? 4'h0 : mFlags) | evt;
    mPrev = cur;
    hist.push_front(pinVec());
    void'(hist.pop_back());
  endtask

  task automatic compare();
    logic [31:0] exp;
    exp = rdNow() ? {24'h0, selNow(), mFlags} : 32'h0;
    check({tag, " model rdData"}, rdData, exp);
    check("R8 model irqOut", {31'h0, irqOut}, {31'h0, irqEn && (mFlags != 0)});
  endtask

  task automatic step();
    @(posedge clk);
    #1 modelEdge();
    @(negedge clk);
    compare();
  endtask

  task automatic randInputs(bit lp, int rdPct);
    {carrierN, ringN, dataSetRdyN, clrToSendN} = 4'($urandom);
    {aux2Ctl, aux1Ctl, termRdyCtl, reqSendCtl} = 4'($urandom);
    loopEn = lp;
    irqEn = 1'($urandom);
    busSel = ($urandom_range(99) < rdPct);
    busWrite = ($urandom_range(9) == 0);
    busAddr = ($urandom_range(7) == 0) ? 6'($urandom) : REG;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    hist = '{4'hF, 4'hF};
    mPrev = 0; mFlags = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    busSel = 1; irqEn = 1;
    check("R1 reset read", rdData, 32'h0);
    check("R8 reset irq", {31'h0, irqOut}, 32'h0);
    step();
    check("R1 idle word", rdData, 32'h0);
    clrToSendN = 0;
    tag = "R3";
    step(); step();
    check("R3 cts visible after two edges", rdData, 32'h10);
    step();
    check("R5 dcts set, kept under read R7", rdData, 32'h11);
    check("R8 irq on flag", {31'h0, irqOut}, 32'h1);
    step();
    check("R7 cleared by read", rdData, 32'h10);
    check("R8 irq drops", {31'h0, irqOut}, 32'h0);
    busSel = 0; ringN = 0; tag = "R6";
    repeat (3) step();
    busSel = 1; #1;
    check("R6 ring fall sets no flag R2", rdData, 32'h50);
    busSel = 0; ringN = 1;
    repeat (3) step();
    busSel = 1; #1;
    check("R6 ring rise sets flag", rdData, 32'h14);
    busWrite = 1; tag = "R9"; #1;
    check("R9 write returns zero", rdData, 32'h0);
    step();
    busWrite = 0; #1;
    check("R9 write did not clear", rdData, 32'h14);
    step();
    busSel = 0; dataSetRdyN = 0; tag = "R10";
    repeat (3) step();
    busSel = 1; busAddr = 6'h04; #1;
    check("R10 other address zero", rdData, 32'h0);
    step();
    busAddr = REG; #1;
    check("R10 flags kept R5", rdData, 32'h32);
    step();
    loopEn = 1; reqSendCtl = 1; aux2Ctl = 1; termRdyCtl = 0; aux1Ctl = 0; tag = "R4";
    #1;
    check("R4 loopback mapping", {24'h0, rdData[7:4], 4'h0}, 32'h90);
    step();
    for (int p = 0; p < 4; p++) begin
      case (p)
        0: tag = "R3 random";
        1: tag = "R4 random";
        2: tag = "R7 random";
        default: tag = "R5 random";
      endcase
      for (int n = 0; n < 3000; n++) begin
        randInputs(p == 1 || (p == 3 && n[6]), (p == 2) ? 70 : 25);
        if (p != 1 && n[0]) {aux2Ctl, aux1Ctl, termRdyCtl, reqSendCtl} = 4'h0;
        step();
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule